// File: doc/BRIEF.md
# Vector Strip-Mining Length Sequencer

This block splits a total element count into a series of vector chunks that a vector unit can process one after another, none longer than the maximum vector length of 64 elements. A start pulse loads the count. For every chunk the block presents a length and the index of the chunk's first element, then holds both until the consumer acknowledges the chunk.

The odd-sized piece goes first: the opening chunk covers `count mod 64` elements and every later chunk covers exactly 64. When the count divides evenly, the opening piece is empty. It is still issued, flagged as zero-length, and it retires on its own after one cycle without waiting for an acknowledge. A one-cycle done pulse follows the retirement of the final chunk. The block computes no data and no memory addresses.

Top module: `strip_seq`

## Requirements
- R1: After reset, chunk_valid_o, done_o and busy_o are all 0.
- R2: A start pulse accepted while idle makes chunk_valid_o 1 on the next cycle, with chunk_vl_o = total_i mod 64 and chunk_low_o = 0.
- R3: Every chunk after the first has chunk_vl_o = 64.
- R4: Each new chunk's chunk_low_o equals the previous chunk's chunk_low_o plus the previous chunk's chunk_vl_o.
- R5: A run issues exactly floor(total_i/64) + 1 chunks (the zero-length one included) before done_o is raised.
- R6: A chunk with chunk_vl_o = 0 has chunk_zero_o = 1, stays valid for exactly one cycle and retires without chunk_ack_i; chunk_zero_o is 0 for every other chunk.
- R7: While a nonzero chunk is valid and chunk_ack_i is 0 at a rising edge, chunk_vl_o and chunk_low_o do not change; an acknowledge sampled high at a rising edge retires the chunk and the next values appear after that edge.
- R8: A start pulse while busy_o is 1 has no effect on the chunk sequence being issued.
- R9: done_o is 1 for exactly one cycle, in the cycle after the final chunk retires, with chunk_valid_o 0; busy_o is 0 in the cycle after that.
- R10: A total of 0 issues only the zero-length chunk and then the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run with total_i (ignored while busy) |
| total_i | input | N_W | Total element count, sampled with start_i |
| chunk_ack_i | input | 1 | Consumer has finished the current chunk |
| chunk_valid_o | output | 1 | A chunk is being presented |
| chunk_vl_o | output | $clog2(MVL)+1 | Length of the current chunk |
| chunk_low_o | output | N_W | Index of the first element of the current chunk |
| chunk_zero_o | output | 1 | Current chunk is empty and retires without acknowledge |
| done_o | output | 1 | One-cycle pulse after the final chunk |
| busy_o | output | 1 | A run is in progress |

## Verification
A wrong remaining-chunk count shows as a done pulse arriving one or more chunks early or late, visible at the first chunk whose presence or length disagrees with the expected sequence. A corrupted cursor shows at the very next chunk as a wrong start index or a length other than 64, and a stuck retire condition shows as a zero-length chunk that lingers past its single cycle or a nonzero chunk that moves without acknowledge. Holding acknowledge low for several cycles and pulsing start mid-run make any unwanted update of the presented values visible within one cycle.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/strip_seq_split.sv
module strip_seq_split #(
  parameter int MVL = 64,
  parameter int N_W = 16,
  localparam int LOG_MVL = $clog2(MVL),
  localparam int VL_W = LOG_MVL + 1,
  localparam int CNT_W = N_W - LOG_MVL
) (
  input  logic [N_W-1:0]   total_i,
  output logic [VL_W-1:0]  first_vl_o,
  output logic [CNT_W-1:0] full_cnt_o
);
  // Length of the odd-sized opening piece: count modulo MVL.
  function automatic logic [VL_W-1:0] odd_len(input logic [N_W-1:0] n);
    return {1'b0, n[LOG_MVL-1:0]};
  endfunction

  // Number of full chunks following the opening piece.
  function automatic logic [CNT_W-1:0] full_chunks(input logic [N_W-1:0] n);
    return n[N_W-1:LOG_MVL];
  endfunction

  always_comb begin
    first_vl_o = odd_len(total_i);
    full_cnt_o = full_chunks(total_i);
  end
endmodule

// File: rtl/strip_seq_fsm.sv
module strip_seq_fsm
  import strip_seq_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ack_i,
  input  logic             zero_i,
  input  logic [CNT_W-1:0] full_cnt_i,
  output logic             load_o,
  output logic             adv_o,
  output logic             valid_o,
  output logic             done_o,
  output logic             busy_o
);
  sq_state_e        state_q;
  logic [CNT_W-1:0] rem_q;
  logic             last_w;

  assign valid_o = (state_q == SQ_RUN);
  assign done_o  = (state_q == SQ_FIN);
  assign busy_o  = (state_q != SQ_IDLE);
  assign load_o  = (state_q == SQ_IDLE) && start_i;
  assign adv_o   = valid_o && (zero_i || ack_i);
  assign last_w  = (rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start_i) begin
          state_q <= SQ_RUN;
          rem_q   <= full_cnt_i;
        end
        SQ_RUN: if (adv_o) begin
          if (last_w) state_q <= SQ_FIN;
          else        rem_q   <= rem_q - 1'b1;
        end
        SQ_FIN:  state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);
  // R9
  done_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o);
  // R8
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && start_i && !adv_o) |=> valid_o && $stable(rem_q));
  // R5
  rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_o && !last_w) |=> valid_o && (rem_q == $past(rem_q) - 1'b1));
  // R6
  zero_autoretire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && zero_i) |-> adv_o);
endmodule

// File: rtl/strip_seq_cursor.sv
module strip_seq_cursor #(
  parameter int MVL = 64,
  parameter int N_W = 16,
  localparam int VL_W = $clog2(MVL) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            adv_i,
  input  logic            valid_i,
  input  logic [VL_W-1:0] first_vl_i,
  output logic [VL_W-1:0] vl_o,
  output logic [N_W-1:0]  low_o,
  output logic            zero_o
);
  localparam logic [VL_W-1:0] FULL_VL = VL_W'(MVL);

  logic [VL_W-1:0] vl_q;
  logic [N_W-1:0]  low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q  <= '0;
      low_q <= '0;
    end else if (load_i) begin
      vl_q  <= first_vl_i;
      low_q <= '0;
    end else if (adv_i) begin
      low_q <= low_q + N_W'(vl_q);
      vl_q  <= FULL_VL;
    end
  end

  assign vl_o   = vl_q;
  assign low_o  = low_q;
  assign zero_o = (vl_q == '0);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !adv_i) |=> $stable(vl_q) && $stable(low_q));
  // R4
  low_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> low_q == $past(low_q) + N_W'($past(vl_q)));
  // R3
  full_after_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> vl_q == FULL_VL);
  // R2
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> vl_q <= FULL_VL);
  // R6
  zero_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && zero_o) |-> low_q == '0);
endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int MVL = 64,
  parameter int N_W = 16,
  localparam int VL_W = $clog2(MVL) + 1,
  localparam int CNT_W = N_W - $clog2(MVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [N_W-1:0]  total_i,
  input  logic            chunk_ack_i,
  output logic            chunk_valid_o,
  output logic [VL_W-1:0] chunk_vl_o,
  output logic [N_W-1:0]  chunk_low_o,
  output logic            chunk_zero_o,
  output logic            done_o,
  output logic            busy_o
);
  logic [VL_W-1:0]  first_vl_w;
  logic [CNT_W-1:0] full_cnt_w;
  logic             load_w;
  logic             adv_w;
  logic             valid_w;
  logic             zero_w;

  strip_seq_split #(.MVL(MVL), .N_W(N_W)) u_split (
    .total_i    (total_i),
    .first_vl_o (first_vl_w),
    .full_cnt_o (full_cnt_w)
  );

  strip_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ack_i      (chunk_ack_i),
    .zero_i     (zero_w),
    .full_cnt_i (full_cnt_w),
    .load_o     (load_w),
    .adv_o      (adv_w),
    .valid_o    (valid_w),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  strip_seq_cursor #(.MVL(MVL), .N_W(N_W)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_w),
    .adv_i      (adv_w),
    .valid_i    (valid_w),
    .first_vl_i (first_vl_w),
    .vl_o       (chunk_vl_o),
    .low_o      (chunk_low_o),
    .zero_o     (zero_w)
  );

  assign chunk_valid_o = valid_w;
  assign chunk_zero_o  = valid_w && zero_w;

  // R2
  first_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> chunk_valid_o && (chunk_low_o == '0));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !chunk_valid_o && !done_o);
endmodule

// File: tb/strip_seq_bench.sv
module strip_seq_bench;
  localparam int MVL = 64;
  localparam int N_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] total_i = '0;
  logic        chunk_ack_i = 1'b0;
  logic        chunk_valid_o;
  logic [6:0]  chunk_vl_o;
  logic [15:0] chunk_low_o;
  logic        chunk_zero_o;
  logic        done_o;
  logic        busy_o;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  strip_seq #(.MVL(MVL), .N_W(N_W)) u_strip_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .total_i       (total_i),
    .chunk_ack_i   (chunk_ack_i),
    .chunk_valid_o (chunk_valid_o),
    .chunk_vl_o    (chunk_vl_o),
    .chunk_low_o   (chunk_low_o),
    .chunk_zero_o  (chunk_zero_o),
    .done_o        (done_o),
    .busy_o        (busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one sequence of total n; gap = idle cycles before each ack;
  // poke = pulse start with another total while the sequence is busy.
  task automatic run_seq(input int n, input int gap, input bit poke, input string req);
    int exp_low = 0;
    int exp_vl = n % MVL;
    int n_chunks = n / MVL + 1;
    @(negedge clk);
    start_i = 1'b1;
    total_i = 16'(n);
    @(negedge clk);
    start_i = 1'b0;
    total_i = 16'hFFFF;
    for (int k = 0; k < n_chunks; k++) begin
      chk(chunk_valid_o == 1'b1, {req, " R2 valid"}, int'(chunk_valid_o), 1);
      chk(int'(chunk_vl_o) == exp_vl, (k == 0) ? {req, " R2 vl"} : {req, " R3 vl"},
          int'(chunk_vl_o), exp_vl);
      chk(int'(chunk_low_o) == exp_low, {req, " R4 low"}, int'(chunk_low_o), exp_low);
      chk(chunk_zero_o == (exp_vl == 0), {req, " R6 zero flag"}, int'(chunk_zero_o),
          int'(exp_vl == 0));
      chk(done_o == 1'b0, {req, " R5 no early done"}, int'(done_o), 0);
      if (exp_vl != 0) begin
        for (int g = 0; g < gap; g++) begin
          if (poke && g == 0) begin
            start_i = 1'b1;
            total_i = 16'd7;
          end
          @(negedge clk);
          start_i = 1'b0;
          chk(int'(chunk_vl_o) == exp_vl, {req, " R7/R8 vl held"}, int'(chunk_vl_o), exp_vl);
          chk(int'(chunk_low_o) == exp_low, {req, " R7/R8 low held"}, int'(chunk_low_o), exp_low);
          chk(chunk_valid_o == 1'b1, {req, " R7 still valid"}, int'(chunk_valid_o), 1);
        end
        chunk_ack_i = 1'b1;
        @(negedge clk);
        chunk_ack_i = 1'b0;
      end else begin
        // R6: no ack given, must retire after one cycle
        @(negedge clk);
      end
      exp_low += exp_vl;
      exp_vl = MVL;
    end
    chk(done_o == 1'b1, {req, " R5/R9 done after last chunk"}, int'(done_o), 1);
    chk(chunk_valid_o == 1'b0, {req, " R9 valid low at done"}, int'(chunk_valid_o), 0);
    @(negedge clk);
    chk(done_o == 1'b0, {req, " R9 done single pulse"}, int'(done_o), 0);
    chk(busy_o == 1'b0, {req, " R9 idle after done"}, int'(busy_o), 0);
  endtask

  task automatic test_reset();
    chk(chunk_valid_o == 1'b0, "R1 valid", int'(chunk_valid_o), 0);
    chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
    chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
  endtask

  task automatic test_zero_total();
    run_seq(0, 0, 1'b0, "R10 n=0");
  endtask

  task automatic test_small();
    run_seq(5, 1, 1'b0, "R2 n=5");
  endtask

  task automatic test_exact();
    run_seq(64, 0, 1'b0, "R6 n=64");
    run_seq(192, 1, 1'b0, "R6 n=192");
  endtask

  task automatic test_multi_with_poke();
    run_seq(130, 3, 1'b1, "R8 n=130");
  endtask

  task automatic test_long();
    run_seq(63, 0, 1'b0, "R3 n=63");
    run_seq(1000, 0, 1'b0, "R5 n=1000");
  endtask

  initial begin
    #2000000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_zero_total();
    test_small();
    test_exact();
    test_multi_with_poke();
    test_long();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule